// File: doc/BRIEF.md
# Page Program Buffer

This block sits between the command front-end of a serial flash model and its storage array. When the front-end begins a page-program command, it passes the block the full start address. The buffer keeps the page part of that address and loads a byte pointer from its low eight bits. Each data byte that follows is stored at the pointer, and the pointer then advances. The pointer wraps inside the 256-byte page and never moves into the next page. A stream longer than one page therefore overwrites its own earlier bytes, so only the most recent 256 are kept. A flag per offset records which bytes the command actually supplied.

When the command ends, the front-end reports whether it ended on a byte boundary. A clean end with at least one byte commits the buffer. Any other end aborts it, and nothing is written. On commit the block raises a single-cycle strobe and then walks every offset of the page in ascending order. For each offset whose flag is set, it presents one byte write. The storage side applies each write as `new = old AND data`, so programming can only clear bits. Offsets the command never touched produce no write and keep their stored value.

The controller has five states. `ST_IDLE` waits for a command. `ST_FILL` collects bytes. `ST_COMMIT` raises the commit strobe. `ST_DRAIN` scans the page. `ST_ABORT` raises the abort strobe. The transitions are:
- `ST_IDLE` goes to `ST_FILL` on start. `ST_FILL` restarts itself on a new start.
- `ST_FILL` goes to `ST_COMMIT` on a clean end, or to `ST_ABORT` on a bad or empty end.
- `ST_COMMIT` goes to `ST_DRAIN`.
- `ST_DRAIN` goes to `ST_IDLE` after the last offset.
- `ST_ABORT` goes to `ST_IDLE`.

Top module: `pgbuf_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `wr_valid`, `commit_strobe` and `abort_strobe` are all low.
- R2: `cmd_start` latches `start_addr`. Bits above bit 7 select the page, and every `wr_addr` of that command carries them unchanged. Byte k of the command goes to offset (`start_addr[7:0]` + k) mod 256.
- R3: Bytes that pass offset 255 continue at offset 0 of the same page, for any start offset.
- R4: When more than 256 bytes arrive, each offset holds the last byte sent to it, so the final 256 bytes are programmed.
- R5: When fewer than 256 bytes arrive, only the offsets they reach are written. Every other offset of the page gets no write.
- R6: `cmd_end` with `end_aligned`=1 after at least one byte produces `commit_strobe` high for exactly one cycle. That cycle directly follows the cycle in which `cmd_end` was sampled.
- R7: `cmd_end` with `end_aligned`=0, or with no byte received, produces `abort_strobe` for one cycle and no write at all.
- R8: After the commit cycle, the block spends exactly 256 cycles scanning offsets 0 to 255 in ascending order. It asserts `wr_valid` only on written offsets, with `wr_data` equal to the last byte received for that offset. `busy` then falls.
- R9: Every `cmd_start` clears all per-offset written flags, so no byte of an earlier command is written again.
- R10: `cmd_start`, `byte_valid` and `cmd_end` are ignored while `busy` is high.
- R11: A `cmd_start` during byte collection drops the bytes gathered so far and restarts collection at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start of a page-program command |
| start_addr | input | ADDR_W | Start address, sampled with `cmd_start` |
| byte_valid | input | 1 | A data byte is present |
| byte_data | input | 8 | Data byte |
| cmd_end | input | 1 | End of the command |
| end_aligned | input | 1 | 1 when the command ended on a byte boundary |
| commit_strobe | output | 1 | One-cycle pulse: buffer accepted |
| abort_strobe | output | 1 | One-cycle pulse: command dropped |
| busy | output | 1 | Commit, drain or abort in progress |
| wr_valid | output | 1 | A byte write is presented |
| wr_addr | output | ADDR_W | Address of the byte write |
| wr_data | output | 8 | Value to be ANDed into storage |

## Verification
On every cycle, the assertions check the following:
- the commit pulse lasts one cycle;
- commit and abort never coincide;
- an abort carries no write and returns to idle;
- the page bits hold steady across a drain;
- write offsets only rise within one drain;
- each drain lasts exactly 256 cycles.

Only the bench scenarios can show where each byte lands and which value wins. These scenarios cover wrap-around, overflow, short streams and restarts, applying the AND-into-storage rule. They also show that stale flags and inputs received while busy leave the page untouched.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FILL   = 3'd1,
        ST_COMMIT = 3'd2,
        ST_DRAIN  = 3'd3,
        ST_ABORT  = 3'd4
    } pg_state_e;

endpackage

// File: rtl/pgbuf_wrapctr.sv
// Modulo-2^W counter: load, step, natural wrap.
module pgbuf_wrapctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (step) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/pgbuf_store.sv
// Page data array plus one written-flag per offset.
module pgbuf_store #(
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_flags,
    input  logic              we,
    input  logic [OFF_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFF_W-1:0]  raddr,
    output logic              rflag,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << OFF_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  flag_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (clr_flags) begin
            flag_q <= '0;
        end else if (we) begin
            flag_q[waddr] <= 1'b1;
        end
    end

    assign rdata = mem[raddr];
    assign rflag = flag_q[raddr];

endmodule

// File: rtl/pgbuf_fsm.sv
// Command sequencing: collect, then commit and drain, or abort.
module pgbuf_fsm
    import pgbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic byte_valid,
    input  logic cmd_end,
    input  logic end_aligned,
    input  logic scan_last,
    output logic arm,
    output logic wr_en,
    output logic ld_scan,
    output logic step_scan,
    output logic commit_strobe,
    output logic abort_strobe,
    output logic busy,
    output logic draining
);

    pg_state_e state_q, state_d;
    logic      got_q;

    // state register and byte-seen tracker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            got_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (arm) begin
                got_q <= 1'b0;
            end else if (wr_en) begin
                got_q <= 1'b1;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (cmd_start) begin
                    state_d = ST_FILL;
                end else if (cmd_end) begin
                    if (end_aligned && (got_q || byte_valid)) state_d = ST_COMMIT;
                    else                                      state_d = ST_ABORT;
                end
            end
            ST_COMMIT: state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (scan_last) state_d = ST_IDLE;
            end
            ST_ABORT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        arm           = 1'b0;
        wr_en         = 1'b0;
        ld_scan       = 1'b0;
        step_scan     = 1'b0;
        commit_strobe = 1'b0;
        abort_strobe  = 1'b0;
        busy          = 1'b0;
        draining      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                arm = cmd_start;
            end
            ST_FILL: begin
                arm   = cmd_start;
                wr_en = !cmd_start && byte_valid;
            end
            ST_COMMIT: begin
                commit_strobe = 1'b1;
                ld_scan       = 1'b1;
                busy          = 1'b1;
            end
            ST_DRAIN: begin
                step_scan = 1'b1;
                draining  = 1'b1;
                busy      = 1'b1;
            end
            ST_ABORT: begin
                abort_strobe = 1'b1;
                busy         = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pgbuf_top.sv
// Page program buffer: wrapped collection, masked write-out in offset order.
module pgbuf_top #(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 256,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cmd_end,
    input  logic              end_aligned,
    output logic              commit_strobe,
    output logic              abort_strobe,
    output logic              busy,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic              arm, wr_en, ld_scan, step_scan, draining;
    logic              scan_last, rflag;
    logic [OFF_W-1:0]  wptr, scan_idx;
    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] rdata;

    pgbuf_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_start     (cmd_start),
        .byte_valid    (byte_valid),
        .cmd_end       (cmd_end),
        .end_aligned   (end_aligned),
        .scan_last     (scan_last),
        .arm           (arm),
        .wr_en         (wr_en),
        .ld_scan       (ld_scan),
        .step_scan     (step_scan),
        .commit_strobe (commit_strobe),
        .abort_strobe  (abort_strobe),
        .busy          (busy),
        .draining      (draining)
    );

    // write pointer: wraps inside the page
    pgbuf_wrapctr #(.W(OFF_W)) u_wptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (arm),
        .load_val (start_addr[OFF_W-1:0]),
        .step     (wr_en),
        .value    (wptr)
    );

    // drain scan index
    pgbuf_wrapctr #(.W(OFF_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_scan),
        .load_val ('0),
        .step     (step_scan),
        .value    (scan_idx)
    );

    assign scan_last = &scan_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (arm) begin
            page_q <= start_addr[ADDR_W-1:OFF_W];
        end
    end

    pgbuf_store #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_flags (arm),
        .we        (wr_en),
        .waddr     (wptr),
        .wdata     (byte_data),
        .raddr     (scan_idx),
        .rflag     (rflag),
        .rdata     (rdata)
    );

    assign wr_valid = draining && rflag;
    assign wr_addr  = {page_q, scan_idx};
    assign wr_data  = rdata;

endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk #(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit_strobe,
    input logic              abort_strobe,
    input logic              busy,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr
);

    localparam int CW = OFF_W + 1;
    localparam logic [CW-1:0] SPAN = CW'(1 << OFF_W);

    logic             in_drain, have_last;
    logic [CW-1:0]    cyc;
    logic [OFF_W-1:0] last_off;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_drain  <= 1'b0;
            cyc       <= '0;
            have_last <= 1'b0;
            last_off  <= '0;
        end else begin
            if (commit_strobe) begin
                in_drain  <= 1'b1;
                cyc       <= '0;
                have_last <= 1'b0;
            end else begin
                if (!busy) in_drain <= 1'b0;
                if (in_drain && busy) cyc <= cyc + 1'b1;
            end
            if (wr_valid) begin
                have_last <= 1'b1;
                last_off  <= wr_addr[OFF_W-1:0];
            end
        end
    end

    // R6
    one_cycle_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_strobe |=> !commit_strobe);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_strobe && abort_strobe));

    // R7
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_strobe |-> !wr_valid);

    // R7
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_strobe |=> !busy);

    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid)) |-> (wr_addr[ADDR_W-1:OFF_W] == $past(wr_addr[ADDR_W-1:OFF_W])));

    // R8
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && have_last) |-> (wr_addr[OFF_W-1:0] > last_off));

    // R8
    drain_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_drain && !busy && !commit_strobe) |-> (cyc == SPAN));

    // R10
    commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_strobe |=> (busy && !abort_strobe));

endmodule

bind pgbuf_top pgbuf_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit_strobe (commit_strobe),
    .abort_strobe  (abort_strobe),
    .busy          (busy),
    .wr_valid      (wr_valid),
    .wr_addr       (wr_addr)
);

// File: tb/sim_pgbuf_top.sv
`timescale 1ns/1ps
module sim_pgbuf_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [23:0] start_addr = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        cmd_end = 1'b0;
    logic        end_aligned = 1'b0;
    logic        commit_strobe, abort_strobe, busy, wr_valid;
    logic [23:0] wr_addr;
    logic [7:0]  wr_data;

    always #2.5 clk = ~clk;

    pgbuf_top u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .cmd_end(cmd_end),
        .end_aligned(end_aligned), .commit_strobe(commit_strobe),
        .abort_strobe(abort_strobe), .busy(busy), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int checks = 0;
    int errors = 0;

    // storage model: new = old AND data
    logic [7:0]  store [256];
    bit          wrote [256];
    int          nwr, ncommit, nabort, order_err, page_err, last_off;
    logic [15:0] exp_page;

    function automatic logic [7:0] bval(int seed, int k);
        return 8'(seed * 13 + k * 37 + (k >> 3));
    endfunction

    function automatic logic [7:0] fillv(int fmode, int o);
        return (fmode == 0) ? 8'hFF : (8'(o * 29) ^ 8'h5A);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (commit_strobe) begin
                ncommit++;
                last_off = -1;
            end
            if (abort_strobe) nabort++;
            if (wr_valid) begin
                if (wr_addr[23:8] != exp_page) page_err++;
                if (int'(wr_addr[7:0]) <= last_off) order_err++;
                last_off = int'(wr_addr[7:0]);
                store[wr_addr[7:0]] = store[wr_addr[7:0]] & wr_data;
                wrote[wr_addr[7:0]] = 1'b1;
                nwr++;
            end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic reset_model(int fmode, logic [15:0] page);
        for (int o = 0; o < 256; o++) begin
            store[o] = fillv(fmode, o);
            wrote[o] = 1'b0;
        end
        nwr = 0; ncommit = 0; nabort = 0; order_err = 0; page_err = 0;
        last_off = -1;
        exp_page = page;
    endtask

    task automatic do_start(logic [23:0] a);
        @(negedge clk);
        cmd_start  = 1'b1;
        start_addr = a;
        @(negedge clk);
        cmd_start  = 1'b0;
    endtask

    task automatic do_bytes(int n, int seed);
        for (int k = 0; k < n; k++) begin
            byte_valid = 1'b1;
            byte_data  = bval(seed, k);
            @(negedge clk);
        end
        byte_valid = 1'b0;
    endtask

    task automatic do_end_wait(bit aligned, bit disturb);
        int w;
        cmd_end     = 1'b1;
        end_aligned = aligned;
        @(negedge clk);
        cmd_end     = 1'b0;
        end_aligned = 1'b0;
        w = 0;
        while (busy && w < 600) begin
            if (disturb && w == 40) begin
                cmd_start = 1'b1; start_addr = 24'h00FF00;
                byte_valid = 1'b1; byte_data = 8'h00;
                cmd_end = 1'b1; end_aligned = 1'b1;
            end else begin
                cmd_start = 1'b0; byte_valid = 1'b0;
                cmd_end = 1'b0; end_aligned = 1'b0;
            end
            @(negedge clk);
            w++;
        end
        cmd_start = 1'b0; byte_valid = 1'b0; cmd_end = 1'b0; end_aligned = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", "busy after drain", int'(busy), 0);
    endtask

    task automatic verify(int s, int n, int seed, int fmode, bit commit_exp, string tag);
        int bad = 0;
        int bo = -1, ba = 0, be = 0;
        chk(commit_exp ? "R6" : "R7", "commit pulses", ncommit, commit_exp ? 1 : 0);
        chk(commit_exp ? "R6" : "R7", "abort pulses", nabort, commit_exp ? 0 : 1);
        for (int o = 0; o < 256; o++) begin
            int d = (o - s) & 255;
            bit v = commit_exp && (d < n);
            logic [7:0] e = fillv(fmode, o);
            if (v) e = e & bval(seed, d + ((n - 1 - d) / 256) * 256);
            if (wrote[o] != v || store[o] !== e) begin
                bad++;
                if (bo < 0) begin bo = o; ba = int'(store[o]); be = int'(e); end
            end
        end
        if (bad != 0)
            $display("FAIL %s first bad offset %0d: actual %0d expected %0d", tag, bo, ba, be);
        chk(tag, "page mismatches", bad, 0);
        chk("R8", "write count", nwr, commit_exp ? ((n > 256) ? 256 : n) : 0);
        chk("R8", "order violations", order_err, 0);
        chk("R2", "page errors", page_err, 0);
    endtask

    task automatic run(logic [15:0] page, int s, int n, int seed, int fmode,
                       bit aligned, bit disturb, string tag);
        reset_model(fmode, page);
        do_start({page, 8'(s)});
        do_bytes(n, seed);
        do_end_wait(aligned, disturb);
        verify(s, n, seed, fmode, aligned && n > 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        reset_model(0, 16'h0);
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "wr_valid in reset", int'(wr_valid), 0);
        chk("R1", "strobes in reset", int'(commit_strobe | abort_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", int'({busy, wr_valid, commit_strobe, abort_strobe}), 0);

        run(16'h1234, 0,    256, 1, 0, 1'b1, 1'b0, "R2");
        run(16'h0001, 8'hF0, 32, 2, 0, 1'b1, 1'b0, "R3");
        run(16'h00AA, 8'h10, 300, 3, 0, 1'b1, 1'b0, "R4");
        run(16'h0BEE, 8'h80, 5,  4, 1, 1'b1, 1'b0, "R5");
        run(16'h0077, 8'h33, 256, 6, 1, 1'b1, 1'b0, "R8");
        run(16'h0020, 8'h20, 10, 7, 0, 1'b0, 1'b0, "R7");
        run(16'h0021, 8'h00, 0,  8, 0, 1'b1, 1'b0, "R7");
        // R9: full page then a single byte; stale flags would show as writes
        run(16'h0100, 8'h00, 256, 9, 1, 1'b1, 1'b0, "R9");
        run(16'h0100, 8'h05, 1, 10, 1, 1'b1, 1'b0, "R9");
        // R10: inputs during the drain
        run(16'h0300, 8'h40, 20, 11, 1, 1'b1, 1'b1, "R10");

        // R11: restart during collection
        reset_model(0, 16'h00AB);
        do_start(24'h123410);
        do_bytes(4, 12);
        do_start(24'h00AB70);
        do_bytes(3, 5);
        do_end_wait(1'b1, 1'b0);
        verify(8'h70, 3, 5, 0, 1'b1, "R11");

        // R3 sweep of start offsets and lengths around the page size
        for (int si = 0; si < 4; si++) begin
            for (int ni = 0; ni < 4; ni++) begin
                int s = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 127 : 255;
                int n = (ni == 0) ? 1 : (ni == 1) ? 255 : (ni == 2) ? 256 : 257;
                run(16'(si * 4 + ni + 16'h0400), s, n, 20 + si * 4 + ni, ni & 1,
                    1'b1, 1'b0, "R3");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule